// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block sits beside the fetch stage and predicts, in the same cycle as the fetch, whether the instruction at the current fetch address is a branch that will be taken and where it goes. It keeps a direct-mapped table. Each slot holds a valid bit, an address tag, the last resolved target and a saturating direction counter. A fetch that matches a valid slot returns that slot's prediction. Any other fetch falls back to the next sequential address, which means a not-taken prediction.

When a branch resolves in execute, the update port writes back its real outcome and target. If the branch already owns its slot, the slot's counter and target are adjusted. Otherwise the slot is claimed for that branch. A flush input drops every entry at once, so a pipeline recovery or a context change can start again from an empty table.

Both ports take a plain valid qualifier and never apply back-pressure. A fetch lookup is answered combinationally in the cycle it is presented. An update is taken on the clock edge that ends the cycle in which `upd_valid` is high. There is no ready signal on either side, and the block accepts one fetch and one update every cycle.

Top module: `btb_predictor`

## Requirements
- R1: After reset every slot is invalid, so every fetch reports `pred_hit` = 0 until an update is written.
- R2: A slot is selected by address bits [IDX_LSB+IDX_W-1 : IDX_LSB], where IDX_LSB = log2(STEP_BYTES). The slot hits only when it is valid and its stored tag equals the remaining address bits, which are the bits above the index and the bits below IDX_LSB.
- R3: On a miss, `pred_taken` = 0 and `pred_target` = `fetch_pc` + STEP_BYTES.
- R4: On a hit, `pred_taken` equals the most significant bit of the slot's counter. `pred_target` is the stored target when `pred_taken` is 1, and `fetch_pc` + STEP_BYTES otherwise.
- R5: An update that does not match a valid slot with the same tag claims the indexed slot. It stores the tag and the target. It sets the counter to 2^(CNT_W-1) if the branch was taken and to 2^(CNT_W-1)-1 if it was not taken.
- R6: An update that matches its slot raises the counter by one on a taken outcome and lowers it by one on a not-taken outcome. It also rewrites the stored target.
- R7: The counter stops at 2^CNT_W-1 and at 0 and never wraps.
- R8: If a fetch and an update use the same slot in the same cycle, the fetch sees the slot as it was before that update.
- R9: A flush makes every slot invalid from the next cycle. An update presented in the same cycle as a flush is discarded.
- R10: An update whose tag differs from that of a valid slot at its index replaces that slot, so the previous owner then misses.
- R11: While `fetch_valid` is 0, `pred_hit` and `pred_taken` are 0 and `pred_target` is `fetch_pc` + STEP_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all slots |
| fetch_valid | input | 1 | Qualifies the fetch lookup |
| fetch_pc | input | ADDR_W | Current fetch address |
| pred_hit | output | 1 | Fetch address matches a valid slot |
| pred_taken | output | 1 | Predicted direction is taken |
| pred_target | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | Qualifies a resolved-branch update |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the branch |
| upd_target | input | ADDR_W | Actual target of the branch |

## Verification
The bench builds the block with ADDR_W = 16, IDX_W = 3, CNT_W = 3 and STEP_BYTES = 4, which gives eight slots with 3-bit counters. Random branch addresses are drawn from four tags across the eight indices. This makes slot replacement and tag aliasing frequent, and it often puts a fetch and an update on the same slot in one cycle. With a 3-bit counter, the upper and lower saturation limits are only a few updates away. The directed sequences can therefore count exactly how many opposite outcomes it takes to flip the prediction.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Action taken on the table by a resolved-branch update
  typedef enum logic [1:0] {
    UPD_NONE   = 2'd0,
    UPD_ADJUST = 2'd1,
    UPD_ALLOC  = 2'd2
  } btb_upd_e;
endpackage

// File: rtl/btb_counter_next.sv
module btb_counter_next #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] cur_cnt,
  input  logic             taken,
  input  logic             alloc,
  output logic [CNT_W-1:0] nxt_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] WEAK_T  = CNT_W'(1) << (CNT_W - 1);

  always_comb begin
    if (alloc) begin
      nxt_cnt = taken ? WEAK_T : WEAK_T - 1'b1;
    end else if (taken) begin
      nxt_cnt = (cur_cnt == CNT_MAX) ? cur_cnt : cur_cnt + 1'b1;
    end else begin
      nxt_cnt = (cur_cnt == '0) ? cur_cnt : cur_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/btb_storage.sv
module btb_storage #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6,
  parameter int TAG_W   = 26,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_target,
  input  logic [CNT_W-1:0]  wr_cnt,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic              ra_valid,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [ADDR_W-1:0] ra_target,
  output logic [CNT_W-1:0]  ra_cnt,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic              rb_valid,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [CNT_W-1:0]  rb_cnt
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] valid_d;
  logic [TAG_W-1:0]   tag_q    [ENTRIES];
  logic [ADDR_W-1:0]  target_q [ENTRIES];
  logic [CNT_W-1:0]   cnt_q    [ENTRIES];

  // Per-slot next valid: flush clears, a write to the slot sets
  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    assign valid_d[e] = flush ? 1'b0
                      : ((wr_en && wr_idx == IDX_W'(e)) ? 1'b1 : valid_q[e]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[wr_idx]    <= wr_tag;
      target_q[wr_idx] <= wr_target;
      cnt_q[wr_idx]    <= wr_cnt;
    end
  end

  assign ra_valid  = valid_q[ra_idx];
  assign ra_tag    = tag_q[ra_idx];
  assign ra_target = target_q[ra_idx];
  assign ra_cnt    = cnt_q[ra_idx];
  assign rb_valid  = valid_q[rb_idx];
  assign rb_tag    = tag_q[rb_idx];
  assign rb_cnt    = cnt_q[rb_idx];

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

  assert_write_sets_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
  parameter int ADDR_W     = 32,
  parameter int TAG_W      = 26,
  parameter int CNT_W      = 2,
  parameter int STEP_BYTES = 4
) (
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic [TAG_W-1:0]  fetch_tag,
  input  logic              ent_valid,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [ADDR_W-1:0] ent_target,
  input  logic [CNT_W-1:0]  ent_cnt,
  output logic              hit,
  output logic              taken,
  output logic [ADDR_W-1:0] target
);
  logic [ADDR_W-1:0] seq_pc;

  assign seq_pc = fetch_pc + ADDR_W'(STEP_BYTES);
  assign hit    = fetch_valid && ent_valid && (ent_tag == fetch_tag);
  assign taken  = hit && ent_cnt[CNT_W-1];
  assign target = taken ? ent_target : seq_pc;
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor import btb_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 6,
  parameter int CNT_W      = 2,
  parameter int STEP_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_target,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target
);
  localparam int IDX_LSB = $clog2(STEP_BYTES);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W;
  localparam int HI_LSB  = IDX_LSB + IDX_W;

  logic [IDX_W-1:0]  f_idx, u_idx;
  logic [TAG_W-1:0]  f_tag, u_tag;
  logic              ra_valid, rb_valid;
  logic [TAG_W-1:0]  ra_tag, rb_tag;
  logic [ADDR_W-1:0] ra_target;
  logic [CNT_W-1:0]  ra_cnt, rb_cnt, nxt_cnt;
  btb_upd_e          upd_kind;

  // Tag keeps every address bit outside the index, so a match is exact
  assign f_idx = fetch_pc[HI_LSB-1:IDX_LSB];
  assign u_idx = upd_pc[HI_LSB-1:IDX_LSB];
  assign f_tag = {fetch_pc[ADDR_W-1:HI_LSB], fetch_pc[IDX_LSB-1:0]};
  assign u_tag = {upd_pc[ADDR_W-1:HI_LSB], upd_pc[IDX_LSB-1:0]};

  always_comb begin
    if (!upd_valid || flush)              upd_kind = UPD_NONE;
    else if (rb_valid && rb_tag == u_tag) upd_kind = UPD_ADJUST;
    else                                  upd_kind = UPD_ALLOC;
  end

  btb_counter_next #(.CNT_W(CNT_W)) u_cnt (
    .cur_cnt (rb_cnt),
    .taken   (upd_taken),
    .alloc   (upd_kind == UPD_ALLOC),
    .nxt_cnt (nxt_cnt)
  );

  btb_storage #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .TAG_W   (TAG_W),
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .wr_en     (upd_kind != UPD_NONE),
    .wr_idx    (u_idx),
    .wr_tag    (u_tag),
    .wr_target (upd_target),
    .wr_cnt    (nxt_cnt),
    .ra_idx    (f_idx),
    .ra_valid  (ra_valid),
    .ra_tag    (ra_tag),
    .ra_target (ra_target),
    .ra_cnt    (ra_cnt),
    .rb_idx    (u_idx),
    .rb_valid  (rb_valid),
    .rb_tag    (rb_tag),
    .rb_cnt    (rb_cnt)
  );

  btb_lookup #(
    .ADDR_W     (ADDR_W),
    .TAG_W      (TAG_W),
    .CNT_W      (CNT_W),
    .STEP_BYTES (STEP_BYTES)
  ) u_look (
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .fetch_tag   (f_tag),
    .ent_valid   (ra_valid),
    .ent_tag     (ra_tag),
    .ent_target  (ra_target),
    .ent_cnt     (ra_cnt),
    .hit         (pred_hit),
    .taken       (pred_taken),
    .target      (pred_target)
  );

  assert_miss_sequential_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> (!pred_taken && pred_target == fetch_pc + ADDR_W'(STEP_BYTES)));

  assert_idle_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> !pred_hit);

  assert_taken_needs_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> pred_hit);

  assert_no_wrap_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_kind == UPD_ADJUST && upd_taken) |-> (nxt_cnt >= rb_cnt));

  assert_no_wrap_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_kind == UPD_ADJUST && !upd_taken) |-> (nxt_cnt <= rb_cnt));
endmodule

// File: tb/btb_predictor_bench.sv
module btb_predictor_bench;
  localparam int AW = 16;
  localparam int NE = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic          pred_hit, pred_taken;
  logic [AW-1:0] pred_target;
  logic          upd_valid = 1'b0;
  logic [AW-1:0] upd_pc = '0;
  logic          upd_taken = 1'b0;
  logic [AW-1:0] upd_target = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state
  bit          m_valid [NE];
  logic [12:0] m_tag   [NE];
  logic [15:0] m_tgt   [NE];
  int          m_cnt   [NE];

  always #2 clk = ~clk;

  btb_predictor #(.ADDR_W(AW), .IDX_W(3), .CNT_W(3), .STEP_BYTES(4)) u_btb_predictor (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target)
  );

  function automatic int idx_of(logic [15:0] pc);
    return int'(pc[4:2]);
  endfunction

  function automatic logic [12:0] tag_of(logic [15:0] pc);
    return {pc[15:5], pc[1:0]};
  endfunction

  task automatic check_out(string req, bit fv, logic [15:0] fpc);
    int  i;
    bit  eh, et;
    logic [15:0] etg;
    i   = idx_of(fpc);
    eh  = fv && m_valid[i] && (m_tag[i] == tag_of(fpc));
    et  = eh && (m_cnt[i] >= 4);
    etg = et ? m_tgt[i] : fpc + 16'd4;
    checks++;
    if (pred_hit !== eh || pred_taken !== et || pred_target !== etg) begin
      errors++;
      $display("FAIL %s pc=%h: got hit=%b taken=%b tgt=%h, expected hit=%b taken=%b tgt=%h",
               req, fpc, pred_hit, pred_taken, pred_target, eh, et, etg);
    end
  endtask

  task automatic model_update(bit fl, bit uv, logic [15:0] upc, bit ut, logic [15:0] utg);
    int i;
    if (fl) begin
      for (int k = 0; k < NE; k++) m_valid[k] = 1'b0;
    end else if (uv) begin
      i = idx_of(upc);
      if (m_valid[i] && m_tag[i] == tag_of(upc)) begin
        if (ut) m_cnt[i] = (m_cnt[i] == 7) ? 7 : m_cnt[i] + 1;
        else    m_cnt[i] = (m_cnt[i] == 0) ? 0 : m_cnt[i] - 1;
      end else begin
        m_cnt[i] = ut ? 4 : 3;
      end
      m_valid[i] = 1'b1;
      m_tag[i]   = tag_of(upc);
      m_tgt[i]   = utg;
    end
  endtask

  // One cycle: drive at the falling edge, check before the rising edge, then advance the model
  task automatic step(string req, bit fv, logic [15:0] fpc, bit uv, logic [15:0] upc,
                      bit ut, logic [15:0] utg, bit fl);
    @(negedge clk);
    fetch_valid = fv; fetch_pc = fpc;
    upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
    flush = fl;
    #1;
    check_out(req, fv, fpc);
    @(posedge clk);
    model_update(fl, uv, upc, ut, utg);
  endtask

  task automatic look(string req, logic [15:0] pc);
    step(req, 1'b1, pc, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0);
  endtask

  task automatic upd(string req, logic [15:0] pc, bit t, logic [15:0] tg);
    step(req, 1'b1, pc, 1'b1, pc, t, tg, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] pa, pb, pc_c;
    for (int k = 0; k < NE; k++) begin
      m_valid[k] = 1'b0; m_cnt[k] = 0; m_tag[k] = '0; m_tgt[k] = '0;
    end
    pa   = 16'h0024;
    pb   = 16'h0048;
    pc_c = 16'h0124;   // same index as pa, different tag

    // R1: reset state, checked while reset is still held and just after
    repeat (2) @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = pa; #1;
    check_out("R1", 1'b1, pa);
    @(negedge clk); rst_n = 1'b1;
    look("R1", pa);
    look("R3", 16'h0040);

    // R5: allocation in both directions
    upd("R5", pa, 1'b1, 16'h0200);
    look("R5", pa);
    upd("R5", pb, 1'b0, 16'h0300);
    look("R5", pb);

    // R8: fetch and update on the same slot in the same cycle see old contents
    upd("R8", pa, 1'b0, 16'h0280);
    look("R8", pa);

    // R6 then R7: climb to the top, count the not-taken steps to flip
    for (int k = 0; k < 6; k++) upd("R6", pa, 1'b1, 16'h0220);
    for (int k = 0; k < 5; k++) begin
      upd("R7", pa, 1'b0, 16'h0220);
      look("R7", pa);
    end
    for (int k = 0; k < 6; k++) upd("R7", pa, 1'b0, 16'h0220);
    for (int k = 0; k < 5; k++) begin
      upd("R7", pa, 1'b1, 16'h0240);
      look("R7", pa);
    end

    // R10: replacement by a different tag on the same index
    upd("R10", pc_c, 1'b1, 16'h0500);
    look("R10", pa);
    look("R10", pc_c);

    // R11: idle fetch reports no hit even on a live slot
    step("R11", 1'b0, pc_c, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0);

    // R9: flush discards a concurrent update and clears every slot
    step("R9", 1'b1, pb, 1'b1, 16'h0060, 1'b1, 16'h0700, 1'b1);
    look("R9", 16'h0060);
    look("R9", pb);
    look("R9", pc_c);

    // R2, R4, R6, R8: random traffic over four tags and eight indices
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] fp, up, tg;
      bit fv, uv, tk, fl;
      fp = 16'(((($urandom % 4) << 5) | (($urandom % 8) << 2)));
      up = ($urandom % 3 == 0) ? fp : 16'(((($urandom % 4) << 5) | (($urandom % 8) << 2)));
      tg = 16'($urandom) & 16'hFFFC;
      fv = ($urandom % 8) != 0;
      uv = ($urandom % 2) != 0;
      tk = ($urandom % 3) != 0;
      fl = ($urandom % 200) == 0;
      step("R2/R4", fv, fp, uv, up, tk, tg, fl);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule